// File: doc/BRIEF.md
# Interrupt and Reset Vector Sequencer

This block sits next to a small 8-bit processor core and decides when program flow is redirected, and to where. It watches four active-low event lines: reset, a non-maskable interrupt, a maskable interrupt request and a set-overflow line. It also watches a ready input, the core's interrupt-disable status bit and a strobe from the core that marks the end of an instruction. When a redirect is due, the sequencer reads two bytes from the fixed vector pair that belongs to the winning event. It joins them into a new program counter, hands that value to the core, and flags the opcode fetch at the new address.

There are three vector pairs. The non-maskable interrupt uses 0xFFFA/0xFFFB, reset uses 0xFFFC/0xFFFD and the maskable request uses 0xFFFE/0xFFFF. In each pair the lower address holds the low byte of the program counter. Reset is level-held: while the line is low the sequencer stays quiet, and the vector read begins only once the line is released. The non-maskable interrupt is edge-latched. The maskable request is a level that is sampled at each instruction boundary and is gated by the disable bit. Both interrupts wait for an instruction boundary. A low ready input stretches any read cycle that is in progress. A falling edge on the set-overflow line produces a one-cycle pulse toward the core's status register.

The controller is a five-state machine:
- HOLD: entered asynchronously while reset is low.
- IDLE: waits for a redirect.
- VEC_LO: reads the low vector byte.
- VEC_HI: reads the high vector byte.
- FETCH: the opcode fetch at the new program counter.

Its transitions are:
- HOLD→VEC_LO on the first clock after reset is released.
- IDLE→VEC_LO when the boundary strobe is high and a request is pending.
- VEC_LO→VEC_HI when ready is high.
- VEC_HI→FETCH when ready is high.
- FETCH→IDLE when ready is high.
- Any state→HOLD while reset is low.

Top module: `redirect_sequencer`

## Requirements
- R1: While `rst_req_n` is low, `bus_rd`, `pc_load` and `opcode_fetch` stay 0, whatever the other inputs do.
- R2: On the first clock after `rst_req_n` rises, the block reads 0xFFFC and then 0xFFFD. The new program counter is {byte at 0xFFFD, byte at 0xFFFC}.
- R3: A falling edge on `nmi_req_n` is latched. At the next boundary the block reads 0xFFFA, then 0xFFFB, whatever `irq_disable` is. A line held low is serviced once only.
- R4: With `irq_req_n` low and `irq_disable` at 0, a boundary starts a read of 0xFFFE and then 0xFFFF. With `irq_disable` at 1 the request is ignored.
- R5: Interrupts start only in a cycle where `insn_done` is high while the block is idle. Pending requests without that strobe cause no bus read.
- R6: If both interrupts are pending at one boundary, the non-maskable one is served first. Reset aborts a sequence in progress and discards a latched non-maskable request.
- R7: While `ready` is low, the current read keeps its address and `bus_rd` stays high. The sequence resumes when `ready` returns high.
- R8: With `ready` high, the low-byte read appears in the cycle after the trigger edge, the high-byte read one cycle later, and the fetch one cycle after that. During the fetch cycle `pc_load` is high for exactly one cycle.
- R9: `opcode_fetch` is high in the fetch cycle, with `bus_addr` equal to `pc_value`. In idle it follows `core_fetch`. During both vector reads it is low.
- R10: A falling edge on `ovf_set_n` gives a one-cycle pulse on `ovf_set_pulse` after the next clock. A line held low gives no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_req_n | input | 1 | Active-low reset line; also resets the block |
| nmi_req_n | input | 1 | Active-low non-maskable interrupt, edge-latched |
| irq_req_n | input | 1 | Active-low maskable interrupt request, level |
| ovf_set_n | input | 1 | Active-low set-overflow line |
| ready | input | 1 | High lets the current read cycle complete |
| irq_disable | input | 1 | Interrupt-disable status bit from the core |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| core_fetch | input | 1 | Core's own opcode-fetch indication while idle |
| rd_data | input | DATA_W | Read data from memory |
| bus_addr | output | 2*DATA_W | Read address |
| bus_rd | output | 1 | Read cycle in progress |
| opcode_fetch | output | 1 | Current cycle fetches an opcode |
| pc_load | output | 1 | Load `pc_value` into the core's program counter |
| pc_value | output | 2*DATA_W | Assembled program counter |
| ovf_set_pulse | output | 1 | One-cycle request to set the overflow flag |

## Verification
Several properties are checked by assertions on every cycle:
- the exit from HOLD into the reset vector read;
- idle being kept without a boundary strobe;
- the address being held during a ready stall;
- the high byte being read at the low address plus one;
- the single-cycle load pulse, with the fetch address matching it;
- the non-maskable pending flag clearing only when that request is taken;
- single-cycle overflow pulses;
- the non-maskable vector winning at a boundary.

Other behaviours can only be shown by the bench's scenarios:
- the vector values actually assembled from memory;
- masking of the maskable request;
- one-shot service of a non-maskable line held low;
- reset aborting a sequence and dropping a latched request;
- quietness while reset is held.

// File: rtl/redirect_pkg.sv
package redirect_pkg;

    // Redirect source; SRC_NONE means nothing is pending
    typedef enum logic [1:0] {
        SRC_RESET = 2'd0,
        SRC_NMI   = 2'd1,
        SRC_IRQ   = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_IDLE   = 3'd1,
        ST_VEC_LO = 3'd2,
        ST_VEC_HI = 3'd3,
        ST_FETCH  = 3'd4
    } seq_state_e;

    // Distance of each vector pair's low address below the top of memory
    localparam int unsigned NMI_OFS = 5;
    localparam int unsigned RST_OFS = 3;
    localparam int unsigned IRQ_OFS = 1;

endpackage

// File: rtl/redirect_capture.sv
module redirect_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic ovf_n,
    input  logic take_nmi,
    output logic nmi_pend,
    output logic ovf_pulse
);
    logic [1:0] line_n;
    logic [1:0] prev_n;
    logic [1:0] fell;

    assign line_n = {ovf_n, nmi_n};

    // One falling-edge detector per active-low line
    for (genvar g = 0; g < 2; g++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_n[g] <= 1'b1;
            else        prev_n[g] <= line_n[g];
        end
        assign fell[g] = prev_n[g] & ~line_n[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pend  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= fell[1];
            if (fell[0])       nmi_pend <= 1'b1;
            else if (take_nmi) nmi_pend <= 1'b0;
        end
    end

    assert_nmi_cleared_by_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_pend) |-> $past(take_nmi));

    assert_ovf_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

endmodule

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
    import redirect_pkg::*;
(
    input  logic nmi_pend,
    input  logic irq_n,
    input  logic irq_disable,
    output src_e pick
);
    logic irq_ok;

    assign irq_ok = ~irq_n & ~irq_disable;

    // Fixed priority: latched NMI ahead of the maskable level
    always_comb begin
        if (nmi_pend)    pick = SRC_NMI;
        else if (irq_ok) pick = SRC_IRQ;
        else             pick = SRC_NONE;
    end

endmodule

// File: rtl/redirect_fsm.sv
module redirect_fsm
    import redirect_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              insn_done,
    input  logic              core_fetch,
    input  src_e              pick,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              opcode_fetch,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              take_nmi
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NMI_LO   = TOP_ADDR - ADDR_W'(NMI_OFS);
    localparam logic [ADDR_W-1:0] RST_LO   = TOP_ADDR - ADDR_W'(RST_OFS);
    localparam logic [ADDR_W-1:0] IRQ_LO   = TOP_ADDR - ADDR_W'(IRQ_OFS);

    seq_state_e        state, state_nx;
    src_e              src_q, src_nx;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] vec_lo;

    // Next-state logic
    always_comb begin
        state_nx = state;
        src_nx   = src_q;
        unique case (state)
            ST_HOLD: begin
                state_nx = ST_VEC_LO;
                src_nx   = SRC_RESET;
            end
            ST_IDLE: begin
                if (insn_done && pick != SRC_NONE) begin
                    state_nx = ST_VEC_LO;
                    src_nx   = pick;
                end
            end
            ST_VEC_LO: if (ready) state_nx = ST_VEC_HI;
            ST_VEC_HI: if (ready) state_nx = ST_FETCH;
            ST_FETCH:  if (ready) state_nx = ST_IDLE;
            default:   state_nx = ST_HOLD;
        endcase
    end

    // State register and captured bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
            src_q <= SRC_RESET;
            lo_q  <= '0;
            pc_q  <= '0;
        end else begin
            state <= state_nx;
            src_q <= src_nx;
            if (state == ST_VEC_LO && ready) lo_q <= rd_data;
            if (state == ST_VEC_HI && ready) pc_q <= {rd_data, lo_q};
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_NMI: vec_lo = NMI_LO;
            SRC_IRQ: vec_lo = IRQ_LO;
            default: vec_lo = RST_LO;
        endcase
    end

    // Outputs
    always_comb begin
        bus_addr     = '0;
        bus_rd       = 1'b0;
        opcode_fetch = 1'b0;
        pc_load      = 1'b0;
        unique case (state)
            ST_IDLE:   opcode_fetch = core_fetch;
            ST_VEC_LO: begin
                bus_addr = vec_lo;
                bus_rd   = 1'b1;
            end
            ST_VEC_HI: begin
                bus_addr = vec_lo + 1'b1;
                bus_rd   = 1'b1;
            end
            ST_FETCH: begin
                bus_addr     = pc_q;
                bus_rd       = 1'b1;
                opcode_fetch = 1'b1;
                pc_load      = ready;
            end
            default: ;
        endcase
    end

    assign pc_value = pc_q;
    assign take_nmi = (state == ST_IDLE) && insn_done && (pick == SRC_NMI);

    assert_release_reads_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_VEC_LO && src_q == SRC_RESET));

    assert_idle_without_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !insn_done) |=> (state == ST_IDLE));

    assert_stall_holds_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !ready) |=> (bus_rd && $stable(bus_addr)));

    assert_hi_follows_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_LO && ready) |=> (bus_addr == $past(bus_addr) + 1'b1));

    assert_load_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

endmodule

// File: rtl/redirect_sequencer.sv
module redirect_sequencer
    import redirect_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_req_n,
    input  logic              nmi_req_n,
    input  logic              irq_req_n,
    input  logic              ovf_set_n,
    input  logic              ready,
    input  logic              irq_disable,
    input  logic              insn_done,
    input  logic              core_fetch,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              opcode_fetch,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              ovf_set_pulse
);
    localparam logic [ADDR_W-1:0] NMI_ADDR = {ADDR_W{1'b1}} - ADDR_W'(NMI_OFS);

    logic nmi_pend;
    logic take_nmi;
    src_e pick;

    redirect_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_req_n),
        .nmi_n     (nmi_req_n),
        .ovf_n     (ovf_set_n),
        .take_nmi  (take_nmi),
        .nmi_pend  (nmi_pend),
        .ovf_pulse (ovf_set_pulse)
    );

    redirect_arbiter u_arbiter (
        .nmi_pend    (nmi_pend),
        .irq_n       (irq_req_n),
        .irq_disable (irq_disable),
        .pick        (pick)
    );

    redirect_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_req_n),
        .ready        (ready),
        .insn_done    (insn_done),
        .core_fetch   (core_fetch),
        .pick         (pick),
        .rd_data      (rd_data),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .opcode_fetch (opcode_fetch),
        .pc_load      (pc_load),
        .pc_value     (pc_value),
        .take_nmi     (take_nmi)
    );

    assert_fetch_at_new_pc_R9: assert property (@(posedge clk) disable iff (!rst_req_n)
        pc_load |-> (opcode_fetch && bus_addr == pc_value));

    // Idle with no read, latched NMI and a boundary: the NMI vector must be next
    assert_nmi_beats_irq_R6: assert property (@(posedge clk) disable iff (!rst_req_n)
        (nmi_pend && insn_done && !bus_rd) |=> (bus_addr == NMI_ADDR));

endmodule

// File: tb/sim_redirect_sequencer.sv
module sim_redirect_sequencer;
    logic        clk = 1'b0;
    logic        rst_req_n, nmi_req_n, irq_req_n, ovf_set_n;
    logic        ready, irq_disable, insn_done, core_fetch;
    logic [7:0]  rd_data;
    logic [15:0] bus_addr, pc_value;
    logic        bus_rd, opcode_fetch, pc_load, ovf_set_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    redirect_sequencer u0 (
        .clk(clk), .rst_req_n(rst_req_n), .nmi_req_n(nmi_req_n), .irq_req_n(irq_req_n),
        .ovf_set_n(ovf_set_n), .ready(ready), .irq_disable(irq_disable),
        .insn_done(insn_done), .core_fetch(core_fetch), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .opcode_fetch(opcode_fetch),
        .pc_load(pc_load), .pc_value(pc_value), .ovf_set_pulse(ovf_set_pulse)
    );

    // Memory model: vector table plus filler
    always_comb begin
        case (bus_addr)
            16'hFFFA: rd_data = 8'h34;
            16'hFFFB: rd_data = 8'h12;
            16'hFFFC: rd_data = 8'hCD;
            16'hFFFD: rd_data = 8'hAB;
            16'hFFFE: rd_data = 8'h78;
            16'hFFFF: rd_data = 8'h56;
            default:  rd_data = bus_addr[7:0] ^ 8'h5A;
        endcase
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every program-counter load
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (pc_load === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected redirect", pc_value, 0);
                end else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    check(pc_value == e, "R2/R3/R4 vector value", pc_value, e);
                    check(opcode_fetch && bus_addr == e, "R9 fetch at new pc", bus_addr, e);
                end
            end
        end
    end

    // Driver: caller drove the trigger at this negedge
    task automatic run_vector(input logic [15:0] lo_addr, input logic [15:0] vec, input string tag);
        exp_q.push_back(vec);
        @(negedge clk); insn_done = 1'b0; #3;
        check(bus_rd && bus_addr == lo_addr && !opcode_fetch, {tag, " R8 low read"}, bus_addr, lo_addr);
        @(negedge clk); #3;
        check(bus_rd && bus_addr == lo_addr + 16'd1 && !opcode_fetch, {tag, " R8 high read"}, bus_addr, lo_addr + 16'd1);
        @(negedge clk); #3;
        check(pc_load == 1'b1, {tag, " R8 load cycle"}, pc_load, 1);
        @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #3;
            check(!bus_rd && !pc_load, tag, bus_rd, 0);
        end
    endtask

    initial begin
        rst_req_n = 1'b0; nmi_req_n = 1'b1; irq_req_n = 1'b1; ovf_set_n = 1'b1;
        ready = 1'b1; irq_disable = 1'b1; insn_done = 1'b0; core_fetch = 1'b1;

        // R1: held reset stays quiet even with requests and boundaries
        @(negedge clk); irq_disable = 1'b0; irq_req_n = 1'b0; insn_done = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #3;
            check(!bus_rd && !pc_load && !opcode_fetch, "R1 reset held", {bus_rd, pc_load, opcode_fetch}, 0);
        end
        @(negedge clk);
        irq_req_n = 1'b1; insn_done = 1'b0; irq_disable = 1'b1; core_fetch = 1'b0;
        rst_req_n = 1'b1;
        run_vector(16'hFFFC, 16'hABCD, "R2 reset release");

        // R9: idle pass-through of core fetch flag
        core_fetch = 1'b1; #3;
        check(opcode_fetch == 1'b1, "R9 idle follows core", opcode_fetch, 1);
        @(negedge clk); core_fetch = 1'b0; #3;
        check(opcode_fetch == 1'b0, "R9 idle follows core", opcode_fetch, 0);

        // R4: masked request ignored
        @(negedge clk); irq_req_n = 1'b0; irq_disable = 1'b1; insn_done = 1'b1;
        quiet(3, "R4 masked irq ignored");
        // R5: unmasked but no boundary
        @(negedge clk); insn_done = 1'b0; irq_disable = 1'b0;
        quiet(3, "R5 no boundary no redirect");
        @(negedge clk); insn_done = 1'b1; core_fetch = 1'b1;
        run_vector(16'hFFFE, 16'h5678, "R4 irq");
        irq_req_n = 1'b1; core_fetch = 1'b0;

        // R3: NMI with interrupts disabled, held low serviced once
        irq_disable = 1'b1; nmi_req_n = 1'b0;
        @(negedge clk); insn_done = 1'b1;
        run_vector(16'hFFFA, 16'h1234, "R3 nmi");
        insn_done = 1'b1;
        quiet(4, "R3 nmi held low serviced once");
        @(negedge clk); nmi_req_n = 1'b1; insn_done = 1'b0;

        // R6: both pending, NMI first, then IRQ
        @(negedge clk); nmi_req_n = 1'b0; irq_req_n = 1'b0; irq_disable = 1'b0;
        @(negedge clk); insn_done = 1'b1;
        run_vector(16'hFFFA, 16'h1234, "R6 nmi first");
        insn_done = 1'b1;
        run_vector(16'hFFFE, 16'h5678, "R6 irq second");
        irq_req_n = 1'b1; nmi_req_n = 1'b1;

        // R7: ready stalls at the low read and at the fetch
        @(negedge clk); nmi_req_n = 1'b0;
        @(negedge clk); insn_done = 1'b1; exp_q.push_back(16'h1234);
        @(negedge clk); insn_done = 1'b0; ready = 1'b0; #3;
        check(bus_rd && bus_addr == 16'hFFFA, "R7 stall low read", bus_addr, 16'hFFFA);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #3;
            check(bus_rd && bus_addr == 16'hFFFA, "R7 stall holds address", bus_addr, 16'hFFFA);
        end
        @(negedge clk); ready = 1'b1;
        @(negedge clk); #3;
        check(bus_addr == 16'hFFFB, "R7 resume high read", bus_addr, 16'hFFFB);
        @(negedge clk); ready = 1'b0; #3;
        check(bus_addr == 16'h1234 && !pc_load, "R7 stall in fetch", pc_load, 0);
        @(negedge clk); ready = 1'b1; #3;
        check(pc_load == 1'b1, "R7 fetch resumes", pc_load, 1);
        @(negedge clk); nmi_req_n = 1'b1;

        // R10: overflow pulse
        @(negedge clk); ovf_set_n = 1'b0; #3;
        check(ovf_set_pulse == 1'b0, "R10 no pulse before clock", ovf_set_pulse, 0);
        @(negedge clk); #3;
        check(ovf_set_pulse == 1'b1, "R10 pulse", ovf_set_pulse, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #3;
            check(ovf_set_pulse == 1'b0, "R10 held low no repeat", ovf_set_pulse, 0);
        end
        @(negedge clk); ovf_set_n = 1'b1;

        // R6: reset aborts an NMI sequence and drops the request
        @(negedge clk); nmi_req_n = 1'b0;
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0; #3;
        check(bus_addr == 16'hFFFA, "R6 nmi sequence started", bus_addr, 16'hFFFA);
        @(negedge clk); rst_req_n = 1'b0; nmi_req_n = 1'b1; #3;
        check(!bus_rd, "R6 reset aborts sequence", bus_rd, 0);
        @(negedge clk); rst_req_n = 1'b1;
        run_vector(16'hFFFC, 16'hABCD, "R6 reset wins");
        insn_done = 1'b1;
        quiet(3, "R6 dropped nmi not serviced");
        @(negedge clk); insn_done = 1'b0;

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 all redirects completed", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule